// File: doc/BRIEF.md
# Row-Pipelined Pixel Clusterer

The block takes a pixel frame one row per clock, as a hit flag and an ADC sample for every column, and groups the hits into clusters of at most 3x3 pixels. Each column has an identical node. A node exchanges data only with its left and right neighbours and with the pixels directly below it. The block holds two rows at a time: the pending row that is being decided and the incoming row under it. A decision on the pending row happens in the same cycle that the row below it arrives. For the last row of a frame, the decision happens on the next clock, whether or not any input arrives.

For each row, each available pixel works out how many available neighbours it has. A pixel is available when it is a hit that no earlier row has taken. A left-to-right link between the nodes then picks the centres. A pixel gives way to its right neighbour only when that neighbour has a strictly higher count. Otherwise it becomes a centre and takes its right neighbour. A centre also takes the hits directly below it and on both lower diagonals. When a lower pixel can go to two centres, the one with the lower column index gets it. A lower hit that no centre takes stays available and is decided with its own row.

The output appears for each column. In the cycle after a decision, a strobe marks every centre column. Alongside the strobe the block gives the centre's row index, a 9-slot membership mask and nine ADC values.

Top module: `clu_array_top`

## Requirements
- R1: A row is accepted on any clock where `inValid` is high. The decision on a pending row is registered on the edge where the next row of the same frame is taken, or on the first edge after the last row of a frame was taken. Its results show on the outputs during the cycle after that edge.
- R2: A hit with no available neighbours forms a cluster on its own. The mask shows only the centre slot (value 9'h010), and only the strobe for its own column is set.
- R3: Slot k of a 9-bit mask field stands for row offset k/3-1 and column offset k%3-1 from the centre, so slot 4 is the centre and slots 6..8 are the row below. Slots 0..2 (the row above) are always zero.
- R4: The neighbour count of an available pixel is the number of available pixels to its left and right in its own row, plus the number of hits in the three positions below it. The pixel gives way to its right neighbour if and only if that neighbour is available and has a strictly larger count. An equal count leaves the lower column as the centre.
- R5: A pixel whose left neighbour is a centre is taken by that centre. A pixel whose left neighbour gave way to it becomes a centre, and that neighbour is its slot-3 member. No two centres in one row are adjacent.
- R6: A hit in the row below that touches two centres is taken by the centre with the lower column index. A taken pixel never becomes a centre and never counts as available.
- R7: Every hit in a frame belongs to exactly one cluster. Across a frame, the total number of mask bits set equals the number of hits.
- R8: Positions outside the column range, above row 0, and below the last row of a frame count as empty.
- R9: The ADC output for each slot carries the sample of the member pixel in that slot, and zero where the mask bit is clear. Columns with no strobe carry an all-zero mask and all-zero ADC values.
- R10: `cluRow` gives the row index of the centres within the frame. Row indices start at 0 after reset and wrap after `FRAME_ROWS` accepted rows.
- R11: While in reset and right after it, all strobes, masks and ADC outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A row is present on `inHit`/`inAdc` |
| inHit | input | COLS | Hit flag for each column |
| inAdc | input | COLS*ADC_W | ADC sample for each column, column 0 in the low bits |
| cluVld | output | COLS | Cluster-centre strobe for each column |
| cluRow | output | ROW_W | Row index of the decided row |
| cluMask | output | COLS*9 | Membership mask for each column, 9 bits per column |
| cluAdc | output | COLS*9*ADC_W | Member ADC values, per column and slot |

## Verification
The properties assume nothing about the hit pattern itself. They do assume that frames have exactly `FRAME_ROWS` rows and that the first row after reset is row 0, because row alignment comes only from counting accepted rows. The stimulus sends each frame as back-to-back rows followed by one idle cycle. This keeps the frame alignment exact and fixes the output timing of every row, including the flush of the last row. The hit patterns are directed corner cases (edge columns, full rows, shared lower pixels, a pixel giving way) followed by random frames at occupancies from 2% to 40%. Each frame is checked against a left-to-right software model of the contest.

// File: rtl/clu_pkg.sv
package clu_pkg;
  localparam int SLOTS = 9;
  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    LNK_NONE  = 2'd0,
    LNK_CLAIM = 2'd1,
    LNK_DEFER = 2'd2
  } link_e;

  typedef struct packed {
    logic decide;
    logic load;
    logic belowUse;
  } ctl_t;
endpackage

// File: rtl/clu_node.sv
module clu_node
  import clu_pkg::*;
(
  input  logic             avail,
  input  logic             leftAvail,
  input  logic             rightAvail,
  input  logic [2:0]       below,
  input  logic             farLeftCentre,
  input  link_e            linkIn,
  input  logic [CNT_W-1:0] rightCnt,
  output logic [CNT_W-1:0] cnt,
  output link_e            linkOut,
  output logic             centre,
  output logic [SLOTS-1:0] mask
);
  logic giveWay;

  assign cnt = CNT_W'(leftAvail) + CNT_W'(rightAvail) + CNT_W'(below[0])
             + CNT_W'(below[1]) + CNT_W'(below[2]);

  assign giveWay = avail && (linkIn == LNK_NONE) && rightAvail && (rightCnt > cnt);

  assign centre = avail && ((linkIn == LNK_DEFER) || ((linkIn == LNK_NONE) && !giveWay));

  always_comb begin
    if (!avail || linkIn == LNK_CLAIM) linkOut = LNK_NONE;
    else if (giveWay)                  linkOut = LNK_DEFER;
    else                               linkOut = LNK_CLAIM;
  end

  always_comb begin
    mask    = '0;
    mask[3] = centre && (linkIn == LNK_DEFER);
    mask[4] = centre;
    mask[5] = centre && rightAvail;
    mask[6] = centre && below[0] && !farLeftCentre;
    mask[7] = centre && below[1];
    mask[8] = centre && below[2];
  end
endmodule

// File: rtl/clu_control.sv
module clu_control
  import clu_pkg::*;
#(
  parameter int FRAME_ROWS = 16,
  parameter int ROW_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output ctl_t             ctl,
  output logic [ROW_W-1:0] cluRow
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(FRAME_ROWS - 1);

  logic             pendValid;
  logic [ROW_W-1:0] pendY;
  logic [ROW_W-1:0] nextY;
  logic             pendLast;

  assign pendLast     = pendValid && (pendY == LAST_ROW);
  assign ctl.decide   = pendValid && (inValid || pendLast);
  assign ctl.load     = inValid;
  assign ctl.belowUse = pendValid && inValid && !pendLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendY     <= '0;
      nextY     <= '0;
      cluRow    <= '0;
    end else begin
      if (inValid) begin
        nextY     <= (nextY == LAST_ROW) ? '0 : nextY + 1'b1;
        pendValid <= 1'b1;
        pendY     <= nextY;
      end else if (ctl.decide) begin
        pendValid <= 1'b0;
      end
      cluRow <= ctl.decide ? pendY : '0;
    end
  end
endmodule

// File: rtl/clu_datapath.sv
module clu_datapath
  import clu_pkg::*;
#(
  parameter int COLS  = 8,
  parameter int ADC_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctl_t                        ctl,
  input  logic [COLS-1:0]             inHit,
  input  logic [COLS*ADC_W-1:0]       inAdc,
  output logic [COLS-1:0]             cluVld,
  output logic [COLS*SLOTS-1:0]       cluMask,
  output logic [COLS*SLOTS*ADC_W-1:0] cluAdc
);
  localparam int ROW_ADC = COLS * ADC_W;
  localparam int MASK_W  = COLS * SLOTS;
  localparam int ADCO_W  = MASK_W * ADC_W;

  logic [COLS-1:0]    pendHit, pendClaim, avail, belowHit, centreV, claimNext;
  logic [ROW_ADC-1:0] pendAdc, belowAdc;
  logic [COLS+1:0]    availPad, belowPad, centrePad;
  logic [ADC_W-1:0]   pAdcPad [COLS+1:0];
  logic [ADC_W-1:0]   bAdcPad [COLS+1:0];
  logic [CNT_W-1:0]   cntArr  [COLS:0];
  link_e              links   [COLS:0];
  logic [MASK_W-1:0]  maskFlat;
  logic [ADCO_W-1:0]  adcFlat;

  assign avail     = pendHit & ~pendClaim;
  assign belowHit  = ctl.belowUse ? inHit : '0;
  assign belowAdc  = ctl.belowUse ? inAdc : '0;
  assign availPad  = {1'b0, avail, 1'b0};
  assign belowPad  = {1'b0, belowHit, 1'b0};
  assign centrePad = {1'b0, centreV, 1'b0};

  assign pAdcPad[0]      = '0;
  assign pAdcPad[COLS+1] = '0;
  assign bAdcPad[0]      = '0;
  assign bAdcPad[COLS+1] = '0;
  assign links[0]        = LNK_NONE;
  assign cntArr[COLS]    = '0;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic farLeft;

    assign pAdcPad[c+1] = pendAdc[c*ADC_W +: ADC_W];
    assign bAdcPad[c+1] = belowAdc[c*ADC_W +: ADC_W];

    if (c >= 2) begin : g_far
      assign farLeft = centreV[c-2];
    end else begin : g_nofar
      assign farLeft = 1'b0;
    end

    clu_node u_node (
      .avail        (avail[c]),
      .leftAvail    (availPad[c]),
      .rightAvail   (availPad[c+2]),
      .below        (belowPad[c+2:c]),
      .farLeftCentre(farLeft),
      .linkIn       (links[c]),
      .rightCnt     (cntArr[c+1]),
      .cnt          (cntArr[c]),
      .linkOut      (links[c+1]),
      .centre       (centreV[c]),
      .mask         (maskFlat[c*SLOTS +: SLOTS])
    );

    assign claimNext[c] = belowHit[c] && (|centrePad[c+2:c]);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      logic [ADC_W-1:0] slotVal;
      if (k < 3) begin : g_top
        assign slotVal = '0;
      end else if (k < 6) begin : g_mid
        assign slotVal = pAdcPad[c+k-3];
      end else begin : g_bot
        assign slotVal = bAdcPad[c+k-6];
      end
      assign adcFlat[(c*SLOTS+k)*ADC_W +: ADC_W] = maskFlat[c*SLOTS+k] ? slotVal : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendHit   <= '0;
      pendClaim <= '0;
      pendAdc   <= '0;
      cluVld    <= '0;
      cluMask   <= '0;
      cluAdc    <= '0;
    end else begin
      if (ctl.load) begin
        pendHit   <= inHit;
        pendAdc   <= inAdc;
        pendClaim <= ctl.belowUse ? claimNext : '0;
      end
      cluVld  <= ctl.decide ? centreV  : '0;
      cluMask <= ctl.decide ? maskFlat : '0;
      cluAdc  <= ctl.decide ? adcFlat  : '0;
    end
  end
endmodule

// File: rtl/clu_array_top.sv
module clu_array_top
  import clu_pkg::*;
#(
  parameter int COLS       = 8,
  parameter int ADC_W      = 8,
  parameter int FRAME_ROWS = 16,
  parameter int ROW_W      = (FRAME_ROWS > 1) ? $clog2(FRAME_ROWS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [COLS-1:0]             inHit,
  input  logic [COLS*ADC_W-1:0]       inAdc,
  output logic [COLS-1:0]             cluVld,
  output logic [ROW_W-1:0]            cluRow,
  output logic [COLS*SLOTS-1:0]       cluMask,
  output logic [COLS*SLOTS*ADC_W-1:0] cluAdc
);
  ctl_t ctl;

  clu_control #(.FRAME_ROWS(FRAME_ROWS), .ROW_W(ROW_W)) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .ctl    (ctl),
    .cluRow (cluRow)
  );

  clu_datapath #(.COLS(COLS), .ADC_W(ADC_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .inHit  (inHit),
    .inAdc  (inAdc),
    .cluVld (cluVld),
    .cluMask(cluMask),
    .cluAdc (cluAdc)
  );
endmodule

// File: rtl/clu_array_chk.sv
module clu_array_chk #(
  parameter int COLS  = 8,
  parameter int ADC_W = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [COLS-1:0]         cluVld,
  input logic [COLS*9-1:0]       cluMask,
  input logic [COLS*9*ADC_W-1:0] cluAdc
);
  // R5: centres in one row are never side by side
  p_no_adjacent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cluVld & (cluVld >> 1)) == '0);

  // R8: nothing is taken from outside the column range
  p_edge_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cluMask[3] && !cluMask[6] && !cluMask[(COLS-1)*9+5] && !cluMask[(COLS-1)*9+8]);

  for (genvar c = 0; c < COLS; c++) begin : g_c
    // R2: a strobed column always includes its own centre slot
    p_centre_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
      cluVld[c] |-> cluMask[c*9+4]);
    // R3: the row above is never part of a cluster
    p_top_row_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
      cluMask[c*9 +: 3] == 3'b000);
    // R9: columns without a strobe carry nothing
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
      !cluVld[c] |-> (cluMask[c*9 +: 9] == '0 && cluAdc[c*9*ADC_W +: 9*ADC_W] == '0));
    if (c + 2 < COLS) begin : g_pair
      // R6: a lower pixel between two centres goes to one of them only
      p_bottom_once_r6: assert property (@(posedge clk) disable iff (!rstN)
        !(cluMask[c*9+8] && cluMask[(c+2)*9+6]));
    end
  end
endmodule

bind clu_array_top clu_array_chk #(.COLS(COLS), .ADC_W(ADC_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .cluVld (cluVld),
  .cluMask(cluMask),
  .cluAdc (cluAdc)
);

// File: tb/clu_array_top_test.sv
module clu_array_top_test;
  localparam int C  = 8;
  localparam int R  = 16;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            inValid = 1'b0;
  logic [C-1:0]    inHit = '0;
  logic [C*AW-1:0] inAdc = '0;
  logic [C-1:0]    cluVld;
  logic [3:0]      cluRow;
  logic [C*9-1:0]  cluMask;
  logic [C*9*AW-1:0] cluAdc;

  int total = 0;
  int bad   = 0;

  bit       fHit [R][C];
  int       fAdc [R][C];
  bit       eVld [R][C];
  bit [8:0] eMask[R][C];
  int       eAdc [R][C][9];

  always #2.5 clk = ~clk;

  clu_array_top #(.COLS(C), .ADC_W(AW), .FRAME_ROWS(R)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inHit(inHit), .inAdc(inAdc),
    .cluVld(cluVld), .cluRow(cluRow), .cluMask(cluMask), .cluAdc(cluAdc)
  );

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit hitAt(int r, int x);
    if (r < 0 || r >= R || x < 0 || x >= C) return 1'b0;
    return fHit[r][x];
  endfunction

  // Expected clustering, scanned left to right per row as the requirements state
  task automatic buildModel();
    bit claim[C];
    bit av[C + 2];
    bit bl[C + 2];
    bit cen[C + 2];
    int cnt[C + 1];
    bit nextClaim[C];
    foreach (claim[x]) claim[x] = 1'b0;
    for (int r = 0; r < R; r++) begin
      for (int x = 0; x < C + 2; x++) begin
        av[x] = 1'b0; bl[x] = 1'b0; cen[x] = 1'b0;
      end
      for (int x = 0; x < C; x++) begin
        av[x+1] = fHit[r][x] && !claim[x];
        bl[x+1] = hitAt(r + 1, x);
      end
      for (int x = 0; x < C; x++)
        cnt[x] = av[x] + av[x+2] + bl[x] + bl[x+1] + bl[x+2];
      cnt[C] = 0;
      begin
        int link = 0;
        for (int x = 0; x < C; x++) begin
          int nxt = 0;
          bit gaveLeft = (link == 2);
          eVld[r][x] = 1'b0; eMask[r][x] = '0;
          for (int k = 0; k < 9; k++) eAdc[r][x][k] = 0;
          if (av[x+1]) begin
            if (link == 1) nxt = 0;
            else if (link == 2) begin cen[x+1] = 1'b1; nxt = 1; end
            else if (av[x+2] && cnt[x+1] > cnt[x]) nxt = 2;
            else begin cen[x+1] = 1'b1; nxt = 1; end
          end
          if (cen[x+1]) begin
            eVld[r][x]     = 1'b1;
            eMask[r][x][4] = 1'b1;
            eMask[r][x][3] = gaveLeft;
            eMask[r][x][5] = av[x+2];
            eMask[r][x][6] = bl[x] && !(x >= 2 && cen[x-1]);
            eMask[r][x][7] = bl[x+1];
            eMask[r][x][8] = bl[x+2];
            for (int d = 0; d < 3; d++) begin
              if (eMask[r][x][3+d]) eAdc[r][x][3+d] = fAdc[r][x-1+d];
              if (eMask[r][x][6+d]) eAdc[r][x][6+d] = fAdc[r+1][x-1+d];
            end
          end
          link = nxt;
        end
      end
      for (int x = 0; x < C; x++)
        nextClaim[x] = bl[x+1] && (cen[x] || cen[x+1] || cen[x+2]);
      foreach (claim[x]) claim[x] = nextClaim[x];
    end
  endtask

  task automatic clearFrame();
    for (int r = 0; r < R; r++)
      for (int x = 0; x < C; x++) begin
        fHit[r][x] = 1'b0;
        fAdc[r][x] = 1 + ((r * 37 + x * 11) % 250);
      end
  endtask

  task automatic runFrame(string tag);
    int hits = 0;
    int members = 0;
    buildModel();
    for (int r = 0; r < R; r++)
      for (int x = 0; x < C; x++) hits += fHit[r][x];
    for (int i = 0; i <= R; i++) begin
      @(negedge clk);
      if (i < R) begin
        inValid = 1'b1;
        for (int x = 0; x < C; x++) begin
          inHit[x] = fHit[i][x];
          inAdc[x*AW +: AW] = AW'(fAdc[i][x]);
        end
      end else begin
        inValid = 1'b0;
        inHit   = '0;
        inAdc   = '0;
      end
      @(posedge clk);
      #1;
      if (i >= 1) begin
        int r = i - 1;
        logic [C-1:0] expV;
        bit any = 1'b0;
        for (int x = 0; x < C; x++) begin
          expV[x] = eVld[r][x];
          any |= eVld[r][x];
        end
        // R1: strobes appear one cycle after the row below is taken
        check(cluVld == expV, tag, $sformatf("R1 strobes row %0d", r), cluVld, expV);
        if (any)
          check(cluRow == 4'(r), tag, "R10 row index", cluRow, r);
        for (int x = 0; x < C; x++) begin
          members += $countones(cluMask[x*9 +: 9]);
          if (eVld[r][x]) begin
            check(cluMask[x*9 +: 9] == eMask[r][x], tag,
                  $sformatf("R3 mask row %0d col %0d", r, x), cluMask[x*9 +: 9], eMask[r][x]);
            for (int k = 0; k < 9; k++)
              check(cluAdc[(x*9+k)*AW +: AW] == AW'(eAdc[r][x][k]), tag,
                    $sformatf("R9 adc row %0d col %0d slot %0d", r, x, k),
                    cluAdc[(x*9+k)*AW +: AW], eAdc[r][x][k]);
          end
        end
      end
    end
    // R7: each hit counted in exactly one cluster
    check(members == hits, tag, "R7 member total", members, hits);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: quiet outputs in reset
    check(cluVld == '0 && cluMask == '0 && cluAdc == '0, "R11", "reset outputs", cluVld, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cluVld == '0 && cluMask == '0, "R11", "after reset", cluVld, 0);

    clearFrame();
    runFrame("R7");

    clearFrame();
    fHit[3][4] = 1'b1; fHit[10][1] = 1'b1;
    runFrame("R2");

    clearFrame();
    fHit[0][0] = 1'b1; fHit[0][7] = 1'b1; fHit[15][0] = 1'b1;
    fHit[15][7] = 1'b1; fHit[7][0] = 1'b1; fHit[8][7] = 1'b1;
    runFrame("R8");

    clearFrame();
    fHit[3][2] = 1'b1; fHit[3][3] = 1'b1; fHit[4][3] = 1'b1; fHit[4][4] = 1'b1;
    runFrame("R4");

    clearFrame();
    for (int x = 0; x < C; x++) fHit[9][x] = 1'b1;
    runFrame("R5");

    clearFrame();
    fHit[6][1] = 1'b1; fHit[6][3] = 1'b1;
    for (int x = 0; x < C; x++) fHit[7][x] = 1'b1;
    runFrame("R6");

    clearFrame();
    for (int r = 0; r < R; r++)
      for (int x = 0; x < C; x++) fHit[r][x] = 1'b1;
    runFrame("R6");

    foreach (fAdc[r, x]) fAdc[r][x] = 0;
    for (int occ = 0; occ < 4; occ++) begin
      int pct = (occ == 0) ? 2 : (occ == 1) ? 5 : (occ == 2) ? 15 : 40;
      for (int f = 0; f < 60; f++) begin
        for (int r = 0; r < R; r++)
          for (int x = 0; x < C; x++) begin
            fHit[r][x] = ($urandom_range(99) < pct);
            fAdc[r][x] = $urandom_range(255, 1);
          end
        runFrame("R4");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule